// File: doc/BRIEF.md
# Byte/Pair General Register Bank

This block holds the working registers of an 8-bit processor core: seven byte registers (an accumulator plus six general registers that group as three 16-bit pairs) and a 16-bit stack pointer. Two combinational read ports and one write port address the byte registers by 3-bit codes. A separate pair-operation port acts on a whole 16-bit pair in one clock. Its operations are immediate load, increment, decrement, swap of the two address pairs, and a 16-bit add into the address pair.

One 3-bit code names no register. Using that code on a port raises a memory-operand indication, and the surrounding core then fetches or stores the byte at the address presented on `hl_addr`. The bank does no byte-wide arithmetic and owns no memory. Its only flag output is the carry from the 16-bit add.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every byte register and the stack pointer are cleared to zero, so `hl_addr` and `sp_out` read 0x0000.
- R2: Byte register codes are A=111, B=000, C=001, D=010, E=011, H=100, L=101. Both read ports return the coded register combinationally. A write with `wr_en` high stores `wr_data` into the coded register at the clock edge.
- R3: Code 110 is the memory operand. A read port given 110 raises its `*_is_mem` output and returns 0x00. A write with code 110 raises `wr_is_mem` in that cycle and changes no register.
- R4: With `pair_op`=001 (load), the pair chosen by `pair_sel` (00=B-C, 01=D-E, 10=H-L, 11=SP) takes `imm_hi` in its high register and `imm_lo` in its low register. SP takes {imm_hi, imm_lo}.
- R5: With `pair_op`=100 (swap), H and D exchange and L and E exchange in one clock.
- R6: With `pair_op`=010, the selected pair increments modulo 65536, with carry from the low byte into the high byte. 0xFFFF becomes 0x0000. `cy_we` stays low.
- R7: With `pair_op`=011, the selected pair decrements modulo 65536, so 0x0000 becomes 0xFFFF. `cy_we` stays low.
- R8: With `pair_op`=101, H-L is replaced by H-L plus the selected pair, truncated to 16 bits. In that same cycle `cy_we` is high and `cy_out` gives the bit-15 carry-out. `cy_we` is low for every other `pair_op`. Codes 000, 110 and 111 do nothing.
- R9: If the byte write and the pair operation hit the same register in one clock, the pair result is stored. A byte write to a register the pair operation does not touch still takes effect.
- R10: During a clock in which a register is written, the read ports return its old value. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_src_code | input | 3 | Register code for source read port |
| rd_dst_code | input | 3 | Register code for destination read port |
| wr_en | input | 1 | Byte write enable |
| wr_code | input | 3 | Register code for byte write |
| wr_data | input | 8 | Byte write data |
| pair_op | input | 3 | Pair operation: 000 none, 001 load, 010 inc, 011 dec, 100 swap, 101 add |
| pair_sel | input | 2 | Pair code: 00 B-C, 01 D-E, 10 H-L, 11 SP |
| imm_hi | input | 8 | High byte for pair load |
| imm_lo | input | 8 | Low byte for pair load |
| rd_src_data | output | 8 | Source read data |
| rd_dst_data | output | 8 | Destination read data |
| src_is_mem | output | 1 | Source code is the memory operand |
| dst_is_mem | output | 1 | Destination code is the memory operand |
| wr_is_mem | output | 1 | Write is enabled with the memory-operand code |
| hl_addr | output | 16 | H-L pair as memory address |
| sp_out | output | 16 | Stack pointer |
| cy_we | output | 1 | Carry update strobe, high during a pair add |
| cy_out | output | 1 | Carry-out of the pair add |

## Verification
A byte write and a pair operation can land on the same register in one clock. The bench provokes this in two ways. It writes H through the byte port while incrementing H-L, and it writes L while swapping. It also writes the accumulator during a swap, to confirm that an untouched register still takes its byte write. Each case is judged by reading every register back after the edge and comparing against a bench model in which the pair result wins. The old value on the read ports during the colliding clock is checked too.

// File: rtl/rf_pkg.sv
// Package rf_pkg: shared codes and the pair-operation type for the register bank.
// Assumes byte codes are 3 bits and pair codes 2 bits; these are encoding facts, not sizes.
package rf_pkg;
    typedef enum logic [2:0] {
        POP_NONE = 3'b000,
        POP_LOAD = 3'b001,
        POP_INC  = 3'b010,
        POP_DEC  = 3'b011,
        POP_SWAP = 3'b100,
        POP_ADD  = 3'b101
    } pair_op_e;

    localparam logic [2:0] CODE_B   = 3'b000;
    localparam logic [2:0] CODE_C   = 3'b001;
    localparam logic [2:0] CODE_D   = 3'b010;
    localparam logic [2:0] CODE_E   = 3'b011;
    localparam logic [2:0] CODE_H   = 3'b100;
    localparam logic [2:0] CODE_L   = 3'b101;
    localparam logic [2:0] CODE_MEM = 3'b110;
    localparam logic [2:0] CODE_A   = 3'b111;

    localparam logic [1:0] PAIR_SP  = 2'b11;
    localparam int         NUM_SLOT = 8;
endpackage

// File: rtl/rf_read_port.sv
// Module rf_read_port: one combinational byte read port over the flattened slot vector.
// Assumes the slot at the memory code is held at zero by the owner of the storage.
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]                 code,
    input  logic [NUM_SLOT*DATA_W-1:0] slots,
    output logic [DATA_W-1:0]          data,
    output logic                       is_mem
);
    // Select the coded slot; the memory slot reads as zero.
    always_comb begin
        data   = slots[int'(code)*DATA_W +: DATA_W];
        is_mem = (code == CODE_MEM);
    end
endmodule

// File: rtl/rf_pair_alu.sv
// Module rf_pair_alu: 16-bit (2*DATA_W) arithmetic for pair operations.
// Assumes the caller routes the result to the correct pair; only the add yields a carry.
module rf_pair_alu
    import rf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PW    = 2 * DATA_W
) (
    input  pair_op_e       op,
    input  logic [PW-1:0]  operand,
    input  logic [PW-1:0]  hl_val,
    input  logic [PW-1:0]  imm,
    output logic [PW-1:0]  result,
    output logic           carry
);
    // Form the pair result for the requested operation.
    always_comb begin
        carry  = 1'b0;
        result = operand;
        unique case (op)
            POP_LOAD: result = imm;
            POP_INC:  result = operand + 1'b1;
            POP_DEC:  result = operand - 1'b1;
            POP_ADD:  {carry, result} = {1'b0, hl_val} + {1'b0, operand};
            default:  result = operand;
        endcase
    end
endmodule

// File: rtl/gpr_bank.sv
// Module gpr_bank: byte registers A,B,C,D,E,H,L plus SP, with byte and pair access.
// Slot index equals the byte code; slot 6 (memory code) is never written and stays zero.
// Assumes pair_op values 110/111 behave as no operation.
module gpr_bank
    import rf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PW    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rd_src_code,
    input  logic [2:0]        rd_dst_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_code,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        pair_op,
    input  logic [1:0]        pair_sel,
    input  logic [DATA_W-1:0] imm_hi,
    input  logic [DATA_W-1:0] imm_lo,
    output logic [DATA_W-1:0] rd_src_data,
    output logic [DATA_W-1:0] rd_dst_data,
    output logic              src_is_mem,
    output logic              dst_is_mem,
    output logic              wr_is_mem,
    output logic [PW-1:0]     hl_addr,
    output logic [PW-1:0]     sp_out,
    output logic              cy_we,
    output logic              cy_out
);
    localparam int SW = NUM_SLOT * DATA_W;

    logic [SW-1:0]     slots_q;
    logic [SW-1:0]     slots_nxt;
    logic [PW-1:0]     sp_q;
    logic [PW-1:0]     sp_nxt;
    logic [PW-1:0]     pair_val;
    logic [PW-1:0]     alu_res;
    logic              alu_cy;
    pair_op_e          op;
    int                hi_slot;

    assign op      = pair_op_e'(pair_op);
    assign hi_slot = int'(pair_sel) * 2;

    // Present the H-L pair as an address and the stack pointer.
    always_comb begin
        hl_addr = {slots_q[int'(CODE_H)*DATA_W +: DATA_W], slots_q[int'(CODE_L)*DATA_W +: DATA_W]};
        sp_out  = sp_q;
    end

    // Pick the 16-bit operand named by pair_sel.
    always_comb begin
        if (pair_sel == PAIR_SP) pair_val = sp_q;
        else pair_val = {slots_q[hi_slot*DATA_W +: DATA_W], slots_q[(hi_slot+1)*DATA_W +: DATA_W]};
    end

    rf_pair_alu #(.DATA_W(DATA_W)) i_alu (
        .op      (op),
        .operand (pair_val),
        .hl_val  (hl_addr),
        .imm     ({imm_hi, imm_lo}),
        .result  (alu_res),
        .carry   (alu_cy)
    );

    // Carry strobe and memory-operand write flag.
    always_comb begin
        cy_we     = (op == POP_ADD);
        cy_out    = cy_we & alu_cy;
        wr_is_mem = wr_en & (wr_code == CODE_MEM);
    end

    // Next state: byte write first, then pair operation overrides any shared register.
    always_comb begin
        slots_nxt = slots_q;
        sp_nxt    = sp_q;
        if (wr_en && wr_code != CODE_MEM)
            slots_nxt[int'(wr_code)*DATA_W +: DATA_W] = wr_data;
        unique case (op)
            POP_LOAD, POP_INC, POP_DEC: begin
                if (pair_sel == PAIR_SP) sp_nxt = alu_res;
                else begin
                    slots_nxt[hi_slot*DATA_W +: DATA_W]     = alu_res[PW-1:DATA_W];
                    slots_nxt[(hi_slot+1)*DATA_W +: DATA_W] = alu_res[DATA_W-1:0];
                end
            end
            POP_SWAP: begin
                slots_nxt[int'(CODE_D)*DATA_W +: DATA_W] = slots_q[int'(CODE_H)*DATA_W +: DATA_W];
                slots_nxt[int'(CODE_E)*DATA_W +: DATA_W] = slots_q[int'(CODE_L)*DATA_W +: DATA_W];
                slots_nxt[int'(CODE_H)*DATA_W +: DATA_W] = slots_q[int'(CODE_D)*DATA_W +: DATA_W];
                slots_nxt[int'(CODE_L)*DATA_W +: DATA_W] = slots_q[int'(CODE_E)*DATA_W +: DATA_W];
            end
            POP_ADD: begin
                slots_nxt[int'(CODE_H)*DATA_W +: DATA_W] = alu_res[PW-1:DATA_W];
                slots_nxt[int'(CODE_L)*DATA_W +: DATA_W] = alu_res[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    // One byte register per slot, cleared by reset.
    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) slots_q[g*DATA_W +: DATA_W] <= '0;
            else        slots_q[g*DATA_W +: DATA_W] <= slots_nxt[g*DATA_W +: DATA_W];
        end
    end

    // Stack pointer register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_nxt;
    end

    rf_read_port #(.DATA_W(DATA_W)) i_rd_src (
        .code (rd_src_code), .slots (slots_q), .data (rd_src_data), .is_mem (src_is_mem)
    );

    rf_read_port #(.DATA_W(DATA_W)) i_rd_dst (
        .code (rd_dst_code), .slots (slots_q), .data (rd_dst_data), .is_mem (dst_is_mem)
    );
endmodule

// File: rtl/gpr_bank_sva.sv
// Module gpr_bank_sva: temporal checks on gpr_bank ports, attached by bind.
// Assumes default widths of 8-bit bytes and 16-bit pairs.
module gpr_bank_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  pair_op,
    input logic [1:0]  pair_sel,
    input logic [7:0]  imm_hi,
    input logic [7:0]  imm_lo,
    input logic        wr_is_mem,
    input logic        src_is_mem,
    input logic [7:0]  rd_src_data,
    input logic [15:0] hl_addr,
    input logic [15:0] sp_out,
    input logic        cy_we
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (sp_out == 16'h0000 && hl_addr == 16'h0000));

    a_r3_mem_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        src_is_mem |-> rd_src_data == 8'h00);

    a_r3_mem_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_is_mem && pair_op == 3'b000) |=> ($stable(hl_addr) && $stable(sp_out)));

    a_r4_load_hl: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op == 3'b001 && pair_sel == 2'b10) |=> hl_addr == $past({imm_hi, imm_lo}));

    a_r4_load_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op == 3'b001 && pair_sel == 2'b11) |=> sp_out == $past({imm_hi, imm_lo}));

    a_r6_inc_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op == 3'b010 && pair_sel == 2'b11) |=> sp_out == $past(sp_out) + 16'd1);

    a_r7_dec_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op == 3'b011 && pair_sel == 2'b11) |=> sp_out == $past(sp_out) - 16'd1);

    a_r8_add_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op == 3'b101 && pair_sel == 2'b11) |=> hl_addr == $past(hl_addr + sp_out));

    a_r8_carry_only_add: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_op != 3'b101) |-> !cy_we);
endmodule

bind gpr_bank gpr_bank_sva i_gpr_bank_sva (.*);

// File: tb/test_gpr_bank.sv
// Bench test_gpr_bank: directed scenarios, each task checks its own results against a model.
module test_gpr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_src_code = 3'b000, rd_dst_code = 3'b000, wr_code = 3'b000, pair_op = 3'b000;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00, imm_hi = 8'h00, imm_lo = 8'h00;
    logic [1:0]  pair_sel = 2'b00;
    logic [7:0]  rd_src_data, rd_dst_data;
    logic        src_is_mem, dst_is_mem, wr_is_mem, cy_we, cy_out;
    logic [15:0] hl_addr, sp_out;

    int vectors = 0;
    int fails   = 0;

    logic [7:0]  m [8];
    logic [15:0] msp;
    logic        obs_cy_we, obs_cy, obs_wmem;
    logic [7:0]  obs_src;

    always #10 clk = ~clk;

    gpr_bank i_gpr_bank (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample in-cycle outputs, update model, commit, idle.
    task automatic step(input logic [2:0] op, input logic [1:0] sel, input logic [15:0] imm,
                        input logic we, input logic [2:0] wc, input logic [7:0] wd);
        logic [7:0]  n [8];
        logic [15:0] nsp, pv, res;
        int hs;
        @(negedge clk);
        pair_op = op; pair_sel = sel; imm_hi = imm[15:8]; imm_lo = imm[7:0];
        wr_en = we; wr_code = wc; wr_data = wd;
        #2;
        obs_cy_we = cy_we; obs_cy = cy_out; obs_wmem = wr_is_mem; obs_src = rd_src_data;
        for (int i = 0; i < 8; i++) n[i] = m[i];
        nsp = msp;
        hs  = int'(sel) * 2;
        pv  = (sel == 2'b11) ? msp : {m[hs], m[hs+1]};
        if (we && wc != 3'b110) n[wc] = wd;
        res = pv;
        case (op)
            3'b001: res = imm;
            3'b010: res = pv + 16'd1;
            3'b011: res = pv - 16'd1;
            3'b101: res = {m[4], m[5]} + pv;
            default: ;
        endcase
        if (op == 3'b001 || op == 3'b010 || op == 3'b011) begin
            if (sel == 2'b11) nsp = res;
            else begin n[hs] = res[15:8]; n[hs+1] = res[7:0]; end
        end else if (op == 3'b100) begin
            n[2] = m[4]; n[3] = m[5]; n[4] = m[2]; n[5] = m[3];
        end else if (op == 3'b101) begin
            n[4] = res[15:8]; n[5] = res[7:0];
        end
        @(posedge clk);
        for (int i = 0; i < 8; i++) m[i] = n[i];
        msp = nsp;
        #1;
        pair_op = 3'b000; wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 8; c++) begin
            if (c != 6) begin
                rd_src_code = 3'(c); rd_dst_code = 3'(c);
                #1;
                chk(req, {24'h0, rd_src_data}, {24'h0, m[c]});
                chk(req, {24'h0, rd_dst_data}, {24'h0, m[c]});
            end
        end
        chk(req, {16'h0, hl_addr}, {16'h0, m[4], m[5]});
        chk(req, {16'h0, sp_out}, {16'h0, msp});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        msp = 16'h0000;
        check_all("R1 reset");
    endtask

    task automatic t_byte_codes;
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b111, 8'hA7);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b000, 8'hB0);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b001, 8'hC1);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b010, 8'hD2);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b011, 8'hE3);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b100, 8'h14);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b101, 8'h15);
        check_all("R2 byte codes");
        chk("R2 hl from H,L", {16'h0, hl_addr}, 32'h1415);
    endtask

    task automatic t_mem_code;
        rd_src_code = 3'b110; rd_dst_code = 3'b110;
        #1;
        chk("R3 src mem flag", {31'h0, src_is_mem}, 1);
        chk("R3 dst mem flag", {31'h0, dst_is_mem}, 1);
        chk("R3 mem read data", {24'h0, rd_src_data}, 0);
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b110, 8'h5A);
        chk("R3 write mem flag", {31'h0, obs_wmem}, 1);
        check_all("R3 mem write inert");
    endtask

    task automatic t_load;
        step(3'b001, 2'b00, 16'h1234, 1'b0, 3'b000, 8'h00);
        step(3'b001, 2'b01, 16'h5678, 1'b0, 3'b000, 8'h00);
        step(3'b001, 2'b10, 16'h9ABC, 1'b0, 3'b000, 8'h00);
        step(3'b001, 2'b11, 16'hDEF0, 1'b0, 3'b000, 8'h00);
        check_all("R4 pair load");
        rd_src_code = 3'b000; #1;
        chk("R4 high byte to B", {24'h0, rd_src_data}, 32'h12);
        chk("R4 sp load", {16'h0, sp_out}, 32'hDEF0);
    endtask

    task automatic t_swap;
        step(3'b100, 2'b00, 16'h0, 1'b0, 3'b000, 8'h00);
        check_all("R5 swap");
        chk("R5 hl now old de", {16'h0, hl_addr}, 32'h5678);
    endtask

    task automatic t_inc_dec;
        step(3'b001, 2'b00, 16'h00FF, 1'b0, 3'b000, 8'h00);
        step(3'b010, 2'b00, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R6 inc no carry strobe", {31'h0, obs_cy_we}, 0);
        check_all("R6 inc byte carry");
        step(3'b001, 2'b11, 16'hFFFF, 1'b0, 3'b000, 8'h00);
        step(3'b010, 2'b11, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R6 sp wrap up", {16'h0, sp_out}, 0);
        step(3'b001, 2'b01, 16'h0000, 1'b0, 3'b000, 8'h00);
        step(3'b011, 2'b01, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R7 dec no carry strobe", {31'h0, obs_cy_we}, 0);
        check_all("R7 de wrap down");
        step(3'b011, 2'b11, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R7 sp wrap down", {16'h0, sp_out}, 32'hFFFF);
    endtask

    task automatic t_add;
        step(3'b001, 2'b10, 16'h8000, 1'b0, 3'b000, 8'h00);
        step(3'b001, 2'b00, 16'h8001, 1'b0, 3'b000, 8'h00);
        step(3'b101, 2'b00, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R8 add carry strobe", {31'h0, obs_cy_we}, 1);
        chk("R8 add carry out", {31'h0, obs_cy}, 1);
        chk("R8 add sum", {16'h0, hl_addr}, 32'h0001);
        step(3'b001, 2'b10, 16'h1234, 1'b0, 3'b000, 8'h00);
        step(3'b101, 2'b10, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R8 hl+hl no carry", {31'h0, obs_cy}, 0);
        chk("R8 hl+hl sum", {16'h0, hl_addr}, 32'h2468);
        step(3'b101, 2'b11, 16'h0, 1'b0, 3'b000, 8'h00);
        chk("R8 hl+sp carry", {31'h0, obs_cy}, 1);
        check_all("R8 add only hl");
    endtask

    task automatic t_conflict;
        step(3'b001, 2'b10, 16'h20FF, 1'b0, 3'b000, 8'h00);
        step(3'b010, 2'b10, 16'h0, 1'b1, 3'b100, 8'h55);
        chk("R9 pair beats byte on H", {16'h0, hl_addr}, 32'h2100);
        step(3'b001, 2'b01, 16'h3344, 1'b0, 3'b000, 8'h00);
        step(3'b100, 2'b00, 16'h0, 1'b1, 3'b101, 8'h99);
        chk("R9 swap beats byte on L", {16'h0, hl_addr}, 32'h3344);
        step(3'b100, 2'b00, 16'h0, 1'b1, 3'b111, 8'h6C);
        check_all("R9 untouched byte write lands");
    endtask

    task automatic t_old_read;
        rd_src_code = 3'b000;
        step(3'b000, 2'b00, 16'h0, 1'b1, 3'b000, 8'h3C);
        chk("R10 old value in write cycle", {24'h0, obs_src}, 32'h20);
        #1;
        chk("R10 new value after edge", {24'h0, rd_src_data}, 32'h3C);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_byte_codes();
        t_mem_code();
        t_load();
        t_swap();
        t_inc_dec();
        t_add();
        step(3'b001, 2'b00, 16'h2000, 1'b0, 3'b000, 8'h00);
        t_conflict();
        t_old_read();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule